// File: doc/BRIEF.md
# Multi-Region Image Histogram Engine

The engine builds intensity histograms from a stream of pixels. It can build them for one to four rectangular windows of the frame at the same time. Each pixel carries a valid strobe, x/y coordinates, a two-bit colour-phase tag and a 10-bit level.

The level is scaled by the white-balance gain that belongs to its colour phase, held at full scale, and shifted right to form a bin index. The counter for that bin is then incremented in every enabled window that contains the pixel. All windows share one bin memory. For this reason the bin count the engine actually uses is limited by the number of windows.

A histogram can be accumulated over several frames before the engine signals that it is complete. A narrow write port sets the engine up. Configuration changes are held back until the next frame start. A plain combinational read port exposes the counters so that the result can be inspected.

Top module: `histo_engine`

## Requirements
- R1: Bin-size code `mode[1:0]` selects 32, 64, 128 or 256 bins (codes 0 to 3). The bin index is the gained level shifted right by 10 minus log2 of the bin count, which is 5, 4, 3 or 2 places.
- R2: The effective code is limited by the window count `mode[4:3]`+1. One window allows code 3, two windows allow code 2, and three or four windows allow code 1. A larger request is reduced to that limit.
- R3: `result_words` equals the effective bin count times the number of windows. The counters of window r occupy words r*bins to r*bins+bins-1.
- R4: Gains sit at `gain[8k+7:8k]` for phase k and are unsigned with 5 fraction bits. The gained level is floor(level*gain/32), limited to 1023.
- R5: When `mode[2]` is set (three-channel mode), phase-3 pixels use a gain of exactly 1.0, and the fourth gain field has no effect.
- R6: Window r is set by an x start/end word at address 4+2r and a y start/end word at address 5+2r, with the start in bits [9:0] and the end in bits [25:16]. Both ends are inclusive. A pixel is counted once in every enabled window that contains it. A window whose start is greater than its end counts nothing.
- R7: `mode[11:8]` gives the number of frames to accumulate, and 0 is treated as 1. `frame_done` pulses for one cycle after the `eof` that closes the last frame of the period. The next frame start then clears the counters and starts a new period.
- R8: `busy` rises in the cycle after an `sof` seen while enabled (`ctrl[0]`). It falls in the cycle after `eof`.
- R9: Writes, including the enable bit, take effect only at the next `sof`. Until then `result_words` and the binning of pixels stay unchanged. A write also forces the counters to clear at that `sof`.
- R10: Bin counters saturate at full scale instead of wrapping.
- R11: Pixels presented while `busy` is low change no counter.
- R12: After reset, `busy` and `frame_done` are low, all counters are zero and `result_words` is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| cfg_we | input | 1 | configuration write strobe |
| cfg_addr | input | 4 | word address: 0 ctrl, 1 mode, 2 gains, 4..11 windows |
| cfg_wdata | input | 32 | write data |
| sof | input | 1 | frame start pulse |
| eof | input | 1 | frame end pulse |
| pix_valid | input | 1 | pixel strobe |
| pix_data | input | PIX_W | pixel level |
| pix_x | input | CRD_W | pixel column |
| pix_y | input | CRD_W | pixel row |
| pix_phase | input | 2 | colour-phase tag |
| busy | output | 1 | collecting the current frame |
| frame_done | output | 1 | one-cycle completion pulse |
| result_words | output | MEM_LOG+1 | words in the current result |
| rd_addr | input | MEM_LOG | counter read address |
| rd_data | output | CNT_W | counter value at rd_addr |

## Verification
A pixel presented on a clock edge shows on `rd_data` straight after that edge, because the read path is combinational. `frame_done` and the falling `busy` follow one edge after `eof`. `busy` and a new `result_words` follow one edge after `sof`. The bench changes inputs on falling edges and samples on the next falling edge, so every check lands exactly one register stage after its stimulus. Counters are compared word by word against an arithmetic model only once the frame has ended and the stream is idle.

// File: rtl/histo_engine.sv
module histo_engine #(
  parameter int PIX_W     = 10,
  parameter int CRD_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5,
  parameter int CNT_W     = 20,
  parameter int MEM_LOG   = 8,
  parameter int ACC_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  input  logic               sof,
  input  logic               eof,
  input  logic               pix_valid,
  input  logic [PIX_W-1:0]   pix_data,
  input  logic [CRD_W-1:0]   pix_x,
  input  logic [CRD_W-1:0]   pix_y,
  input  logic [1:0]         pix_phase,
  output logic               busy,
  output logic               frame_done,
  output logic [MEM_LOG:0]   result_words,
  input  logic [MEM_LOG-1:0] rd_addr,
  output logic [CNT_W-1:0]   rd_data
);
  localparam int NREG      = 4;
  localparam int NCFG      = 4 + 2 * NREG;
  localparam int MEM_WORDS = 1 << MEM_LOG;
  localparam int RW_W      = MEM_LOG + 1;
  localparam int PROD_W    = PIX_W + GAIN_W;
  localparam int LB_W      = $clog2(MEM_LOG + 1);

  logic [31:0]      sh  [NCFG];
  logic [31:0]      act [NCFG];
  logic             dirty, in_frame, done_q;
  logic [ACC_W-1:0] left;
  logic [CNT_W-1:0] mem [MEM_WORDS];

  wire [1:0] code_req = act[1][1:0];
  wire       full_col = act[1][2];
  wire [1:0] nr       = act[1][4:3];
  wire [1:0] code_max = (nr == 2'd0) ? 2'd3 : (nr == 2'd1) ? 2'd2 : 2'd1;
  wire [1:0] code     = (code_req > code_max) ? code_max : code_req;
  wire [LB_W-1:0] lb  = LB_W'(MEM_LOG - 3) + LB_W'(code);
  wire [7:0] shamt    = 8'(PIX_W) - 8'(lb);

  assign result_words = RW_W'({1'b0, nr} + 3'd1) << lb;

  wire [GAIN_W-1:0] gain_sel = (full_col && pix_phase == 2'd3) ? GAIN_W'(1 << GAIN_FRAC)
                                                                : act[2][32'(pix_phase) * GAIN_W +: GAIN_W];
  wire [PROD_W-1:0] prod   = PROD_W'(pix_data) * PROD_W'(gain_sel);
  wire [PROD_W-1:0] scaled = prod >> GAIN_FRAC;
  wire [PIX_W-1:0]  level  = (scaled > PROD_W'({PIX_W{1'b1}})) ? '1 : scaled[PIX_W-1:0];

  logic [NREG-1:0]    hit;
  logic [MEM_LOG-1:0] addr [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_win
    wire [CRD_W-1:0] hs = act[4+2*r][CRD_W-1:0];
    wire [CRD_W-1:0] he = act[4+2*r][16 +: CRD_W];
    wire [CRD_W-1:0] vs = act[5+2*r][CRD_W-1:0];
    wire [CRD_W-1:0] ve = act[5+2*r][16 +: CRD_W];
    assign hit[r]  = (r <= int'(nr)) && pix_x >= hs && pix_x <= he && pix_y >= vs && pix_y <= ve;
    assign addr[r] = (MEM_LOG'(r) << lb) | MEM_LOG'(level >> shamt);
  end

  logic unused_cfg;
  always_comb begin
    unused_cfg = 1'b0;
    for (int i = 0; i < NCFG; i++) unused_cfg = unused_cfg ^ (^act[i]);
  end

  wire [ACC_W-1:0] acc_new   = sh[1][8 +: ACC_W];
  wire             start_new = sof && sh[0][0] && (dirty || left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCFG; i++) begin
        sh[i]  <= '0;
        act[i] <= '0;
      end
      dirty    <= 1'b0;
      in_frame <= 1'b0;
      left     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sof) begin
        for (int i = 0; i < NCFG; i++) act[i] <= sh[i];
        dirty    <= 1'b0;
        in_frame <= sh[0][0];
        if (start_new) left <= (acc_new == '0) ? ACC_W'(1) : acc_new;
      end else if (eof && in_frame) begin
        in_frame <= 1'b0;
        if (left <= ACC_W'(1)) begin
          done_q <= 1'b1;
          left   <= '0;
        end else begin
          left <= left - 1'b1;
        end
      end
      if (cfg_we && cfg_addr < 4'(NCFG)) begin
        sh[cfg_addr] <= cfg_wdata;
        dirty        <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start_new) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    end else if (pix_valid && in_frame) begin
      for (int r = 0; r < NREG; r++)
        if (hit[r] && mem[addr[r]] != '1) mem[addr[r]] <= mem[addr[r]] + 1'b1;
    end
  end

  assign busy       = in_frame;
  assign frame_done = done_q;
  assign rd_data    = mem[rd_addr];
endmodule

// File: rtl/histo_engine_chk.sv
module histo_engine_chk #(
  parameter int RW_W      = 9,
  parameter int MEM_WORDS = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sof,
  input logic            eof,
  input logic            busy,
  input logic            frame_done,
  input logic [RW_W-1:0] result_words
);
  p_busy_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !sof && busy) |=> !busy);

  p_done_after_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(eof) && !busy));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_words_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(result_words));

  p_words_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_words <= RW_W'(MEM_WORDS) && result_words >= RW_W'(MEM_WORDS / 8));
endmodule

bind histo_engine histo_engine_chk #(.RW_W(MEM_LOG + 1), .MEM_WORDS(1 << MEM_LOG)) chk_i (
  .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .busy(busy),
  .frame_done(frame_done), .result_words(result_words)
);

// File: tb/histo_engine_tb_top.sv
module histo_engine_tb_top;
  localparam int CW   = 5;
  localparam int CMAX = 31;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        sof = 1'b0, eof = 1'b0, pix_valid = 1'b0;
  logic [9:0]  pix_data = '0, pix_x = '0, pix_y = '0;
  logic [1:0]  pix_phase = '0;
  logic        busy, frame_done;
  logic [8:0]  result_words;
  logic [7:0]  rd_addr = '0;
  logic [CW-1:0] rd_data;

  histo_engine #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sof(sof), .eof(eof), .pix_valid(pix_valid), .pix_data(pix_data), .pix_x(pix_x),
    .pix_y(pix_y), .pix_phase(pix_phase), .busy(busy), .frame_done(frame_done),
    .result_words(result_words), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  int exp_m [256];
  int p_en = 0, p_code = 0, p_fc = 0, p_nr = 0, p_acc = 0;
  int a_code = 0, a_fc = 0, a_nr = 0;
  int p_g [4], a_g [4];
  int p_hs [4], p_he [4], p_vs [4], p_ve [4];
  int a_hs [4], a_he [4], a_vs [4], a_ve [4];
  bit model_on = 0;
  bit d;

  task automatic chk(input string req, input string what, input int got, input int want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, want);
    end
  endtask

  function automatic int eff_code();
    int lim = (a_nr == 0) ? 3 : (a_nr == 1) ? 2 : 1;
    return (a_code > lim) ? lim : a_code;
  endfunction

  function automatic int exp_words();
    return (a_nr + 1) * (32 << eff_code());
  endfunction

  task automatic wr(input int a, input int dat);
    @(negedge clk);
    pix_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 32'(dat);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mode(input int code, input int fc, input int nr, input int acc);
    p_code = code; p_fc = fc; p_nr = nr; p_acc = acc;
    wr(1, code | (fc << 2) | (nr << 3) | (acc << 8));
  endtask

  task automatic set_gains(input int g0, input int g1, input int g2, input int g3);
    p_g[0] = g0; p_g[1] = g1; p_g[2] = g2; p_g[3] = g3;
    wr(2, g0 | (g1 << 8) | (g2 << 16) | (g3 << 24));
  endtask

  task automatic set_win(input int r, input int hs, input int he, input int vs, input int ve);
    p_hs[r] = hs; p_he[r] = he; p_vs[r] = vs; p_ve[r] = ve;
    wr(4 + 2 * r, hs | (he << 16));
    wr(5 + 2 * r, vs | (ve << 16));
  endtask

  task automatic set_en(input int e);
    p_en = e;
    wr(0, e);
  endtask

  task automatic start_frame(input bit clr);
    a_code = p_code; a_fc = p_fc; a_nr = p_nr;
    for (int i = 0; i < 4; i++) begin
      a_g[i] = p_g[i]; a_hs[i] = p_hs[i]; a_he[i] = p_he[i]; a_vs[i] = p_vs[i]; a_ve[i] = p_ve[i];
    end
    @(negedge clk);
    pix_valid = 1'b0; sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    if (clr) for (int i = 0; i < 256; i++) exp_m[i] = 0;
    model_on = (p_en != 0);
    chk("R8", "busy after sof", int'(busy), p_en);
    chk("R3", "result_words after sof", int'(result_words), exp_words());
  endtask

  task automatic end_frame(output bit done_seen);
    @(negedge clk);
    pix_valid = 1'b0; eof = 1'b1;
    @(negedge clk);
    eof = 1'b0;
    done_seen = frame_done;
    model_on = 0;
    chk("R8", "busy after eof", int'(busy), 0);
  endtask

  task automatic px(input int x, input int y, input int ph, input int v);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = 10'(x); pix_y = 10'(y); pix_phase = 2'(ph); pix_data = 10'(v);
    if (model_on) begin
      int g = (a_fc != 0 && ph == 3) ? 32 : a_g[ph];
      int s = (v * g) / 32;
      int c = eff_code();
      int nb = 32 << c;
      if (s > 1023) s = 1023;
      for (int r = 0; r < 4; r++) begin
        if (r <= a_nr && x >= a_hs[r] && x <= a_he[r] && y >= a_vs[r] && y <= a_ve[r]) begin
          int idx = r * nb + (s >> (5 - c));
          if (exp_m[idx] < CMAX) exp_m[idx]++;
        end
      end
    end
  endtask

  task automatic cmp_mem(input string req);
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a);
      #1;
      chk(req, $sformatf("counter %0d", a), int'(rd_data), exp_m[a]);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      p_g[i] = 0; a_g[i] = 0; p_hs[i] = 0; p_he[i] = 0; p_vs[i] = 0; p_ve[i] = 0;
      a_hs[i] = 0; a_he[i] = 0; a_vs[i] = 0; a_ve[i] = 0;
    end
    for (int i = 0; i < 256; i++) exp_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "busy at reset", int'(busy), 0);
    chk("R12", "frame_done at reset", int'(frame_done), 0);
    chk("R12", "result_words at reset", int'(result_words), 32);
    cmp_mem("R12");

    // R1: sweep all four bin sizes with unity gain and a full window
    set_gains(32, 32, 32, 32);
    set_win(0, 0, 1023, 0, 1023);
    set_en(1);
    for (int code = 0; code < 4; code++) begin
      set_mode(code, 0, 0, 1);
      start_frame(1);
      for (int v = 0; v < 1024; v++) px(v, 0, v % 4, v);
      end_frame(d);
      chk("R7", "done with single-frame period", int'(d), 1);
      cmp_mem("R1");
    end

    // R4: distinct gains per phase, including full-scale saturation
    set_gains(16, 32, 48, 200);
    set_mode(3, 0, 0, 1);
    start_frame(1);
    for (int v = 0; v < 1024; v += 3) px(v, 5, v % 4, v);
    end_frame(d);
    cmp_mem("R4");

    // R5: three-channel mode ignores the fourth gain for phase 3
    set_gains(40, 24, 64, 0);
    set_mode(3, 1, 0, 1);
    start_frame(1);
    for (int v = 0; v < 1024; v += 2) px(v, 7, (v / 2) % 4, v);
    end_frame(d);
    cmp_mem("R5");

    // R6 / R2: four windows, inclusive edges, one empty window, code clamped
    set_gains(32, 32, 32, 32);
    set_win(0, 0, 99, 0, 9);
    set_win(1, 50, 149, 5, 14);
    set_win(2, 200, 100, 0, 15);
    set_win(3, 0, 1023, 10, 10);
    set_mode(3, 0, 3, 1);
    start_frame(1);
    chk("R2", "words with four windows", int'(result_words), 256);
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 160; x++) px(x, y, (x % 2) + 2 * (y % 2), (x * 7 + y * 13) % 1024);
    end_frame(d);
    cmp_mem("R6");

    // R2: two windows limit to 128 bins, three windows at 32 bins
    set_win(0, 0, 1023, 0, 1023);
    set_win(1, 0, 1023, 0, 1023);
    set_win(2, 0, 1023, 0, 1023);
    set_mode(3, 0, 1, 1);
    start_frame(1);
    chk("R2", "words with two windows", int'(result_words), 256);
    for (int v = 0; v < 1024; v += 5) px(v, 1, 0, v);
    end_frame(d);
    cmp_mem("R2");
    set_mode(0, 0, 2, 1);
    start_frame(1);
    chk("R3", "words with three windows at 32 bins", int'(result_words), 96);
    for (int v = 0; v < 1024; v += 9) px(v, 2, 1, v);
    end_frame(d);
    cmp_mem("R3");

    // R7: accumulate over three frames, then zero means one
    set_mode(2, 0, 0, 3);
    start_frame(1);
    for (int v = 0; v < 200; v++) px(v, 0, 0, v * 5);
    end_frame(d);
    chk("R7", "done after frame 1 of 3", int'(d), 0);
    start_frame(0);
    for (int v = 0; v < 200; v++) px(v, 0, 0, v * 3);
    end_frame(d);
    chk("R7", "done after frame 2 of 3", int'(d), 0);
    start_frame(0);
    for (int v = 0; v < 200; v++) px(v, 0, 0, 1023 - v);
    end_frame(d);
    chk("R7", "done after frame 3 of 3", int'(d), 1);
    @(negedge clk);
    chk("R7", "done is one cycle", int'(frame_done), 0);
    cmp_mem("R7");
    start_frame(1);
    px(0, 0, 0, 0);
    end_frame(d);
    chk("R7", "done after first frame of new period", int'(d), 0);
    cmp_mem("R7");
    set_mode(2, 0, 0, 0);
    start_frame(1);
    end_frame(d);
    chk("R7", "zero period acts as one", int'(d), 1);
    start_frame(1);
    px(3, 3, 0, 600);
    end_frame(d);
    chk("R7", "zero period repeats", int'(d), 1);

    // R9: a write during a frame waits for the next frame start
    set_mode(3, 0, 0, 1);
    start_frame(1);
    for (int v = 0; v < 100; v++) px(v, 0, 0, v * 10);
    set_mode(0, 0, 1, 1);
    @(negedge clk);
    chk("R9", "words unchanged mid-frame", int'(result_words), 256);
    for (int v = 100; v < 200; v++) px(v, 0, 0, v * 5);
    end_frame(d);
    chk("R9", "words unchanged after eof", int'(result_words), 256);
    cmp_mem("R9");
    start_frame(1);
    chk("R9", "words updated at sof", int'(result_words), 64);
    for (int v = 0; v < 300; v++) px(v, 4, 2, v * 3);
    end_frame(d);
    cmp_mem("R9");

    // R11 / R8: pixels outside a frame and while disabled are ignored
    for (int v = 0; v < 50; v++) px(v, 0, 0, v * 20);
    @(negedge clk);
    pix_valid = 1'b0;
    cmp_mem("R11");
    set_en(0);
    start_frame(0);
    chk("R8", "busy stays low when disabled", int'(busy), 0);
    for (int v = 0; v < 50; v++) px(v, 0, 0, v * 20);
    end_frame(d);
    chk("R7", "no done while disabled", int'(d), 0);
    cmp_mem("R11");

    // R10: counters hold at full scale
    set_en(1);
    set_mode(3, 0, 0, 1);
    start_frame(1);
    for (int i = 0; i < 40; i++) px(1, 1, 0, 400);
    end_frame(d);
    rd_addr = 8'(400 >> 2);
    #1;
    chk("R10", "saturated counter", int'(rd_data), CMAX);
    cmp_mem("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule